// File: doc/BRIEF.md
# Circular Load/Store Queue Tracker

This block keeps the bookkeeping for the memory-ordering queues of an out-of-order core. It has two circular queues, one for loads and one for stores. Each entry holds an instruction sequence number. Store entries also carry a flag that says the store may write back. Memory operations are allocated at the queue tails in program order. Each new entry reports the slot it received and a link to the other queue's tail at that moment, so that later ordering checks know which older or younger entries to compare against.

A commit input carries the youngest committed sequence number. It does two things in the same cycle: it pops every committed load from the load head, and it marks committed stores as eligible to write back. A separate retire strobe frees the store at the head once that store is eligible. A squash input carries a sequence number and rolls both tails back past every younger entry. The store walk halts at the first store that is already eligible. Each queue has one more slot than its usable depth, so that full and empty can be told apart. The block reports the number of operations of either kind that can still be accepted.

Top module: `lsq_tracker`

## Requirements
- R1: After a synchronous active-low reset, both queues are empty and all head and tail indices are 0. With the default depths (4 loads, 3 stores), `free_slots` reads 3.
- R2: A queue is full when advancing its tail by one slot, wrapping at the slot count, lands on its head. An allocation aimed at a full queue is dropped: `alloc_taken` is 0 and nothing changes.
- R3: For an allocation with `alloc_is_store`=0 (load), `alloc_idx` is the load tail and `alloc_link` is the store tail. `alloc_link_none` is 1 exactly when the store queue is empty.
- R4: For an allocation with `alloc_is_store`=1 (store), `alloc_idx` is the store tail, `alloc_link` is the load tail, and `alloc_link_none` is 0.
- R5: `free_slots` equals the smaller of (load depth − load count) and (store depth − store count).
- R6: When `commit_valid` is 1, loads are popped from the head in a single cycle. Popping continues while the head sequence number is ≤ `commit_seq` and stops at the first younger load.
- R7: When `commit_valid` is 1, every held store with sequence number ≤ `commit_seq` becomes eligible. `st_retire` frees the head store only when that store is eligible (`st_head_ready`=1). Otherwise the strobe has no effect.
- R8: When `squash_valid` is 1, trailing loads with sequence number > `squash_seq` are removed. The load tail ends at the head plus the number of loads kept.
- R9: When `squash_valid` is 1, trailing stores are removed under the same rule as loads. The walk stops at the first eligible store, and that store and everything older are kept.
- R10: Indices step from the last slot (slot count − 1) back to 0 on advance. The load queue has 5 slots and the store queue has 4.
- R11: In a squash cycle, allocation, commit and retire are all ignored.
- R12: Counts, heads and tails all take their new values on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocation request this cycle |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_seq | input | SEQ_W | Sequence number of the new entry |
| alloc_taken | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | IDX_W | Slot the new entry receives |
| alloc_link | output | IDX_W | Tail of the other queue |
| alloc_link_none | output | 1 | Load allocated while the store queue is empty |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| st_retire | input | 1 | Free the head store if it is eligible |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries younger than this are removed |
| ld_head | output | IDX_W | Load head index |
| ld_tail | output | IDX_W | Load tail index |
| ld_count | output | CNT_W | Loads held |
| ld_full | output | 1 | Load queue full |
| st_head | output | IDX_W | Store head index |
| st_tail | output | IDX_W | Store tail index |
| st_count | output | CNT_W | Stores held |
| st_full | output | 1 | Store queue full |
| st_head_ready | output | 1 | Head store is held and eligible |
| free_slots | output | CNT_W | Operations of either kind still acceptable |

## Verification
Head and tail indices are ports, so a pointer that wraps at the wrong slot or moves a wrong number of steps shows up on the next edge. It is visible as a mismatch between the tail and the head plus the count. The same error then returns as a wrong `alloc_idx` or `alloc_link` on the following allocation. An eligibility flag that is set or cleared wrongly stays hidden until it reaches the head. At that point it appears as a wrong `st_head_ready`, a retire that frees the wrong store, or a squash that stops at the wrong store, and the store count exposes it one cycle later. The directed scenarios push both queues across their wrap points so that these errors surface within a few cycles.

// File: rtl/lsq_pkg.sv
// Shared definitions for the load/store queue tracker.
// Assumes: sequence numbers grow monotonically in program order and do not wrap.
package lsq_pkg;
    typedef enum logic {
        Q_LOAD  = 1'b0,
        Q_STORE = 1'b1
    } q_kind_e;
endpackage

// File: rtl/lsq_free_calc.sv
// Reports how many operations of either kind can still be accepted.
// The result is the smaller of the spare capacities of the two queues.
// Assumes: each count never exceeds the usable depth of its queue.
module lsq_free_calc #(
    parameter int LD_DEPTH = 4,
    parameter int ST_DEPTH = 3,
    parameter int CNT_W    = 3
) (
    input  logic [CNT_W-1:0] ld_cnt_i,
    input  logic [CNT_W-1:0] st_cnt_i,
    output logic [CNT_W-1:0] free_o
);
    logic [CNT_W-1:0] ld_spare, st_spare;

    // spare capacity per queue, then the minimum of the two
    always_comb begin
        ld_spare = CNT_W'(LD_DEPTH) - ld_cnt_i;
        st_spare = CNT_W'(ST_DEPTH) - st_cnt_i;
        free_o   = (ld_spare < st_spare) ? ld_spare : st_spare;
    end
endmodule

// File: rtl/lsq_ring.sv
// One circular queue of sequence numbers with one sentinel slot.
// KIND selects how entries leave from the head:
//   load  - a commit pops the committed prefix in one cycle;
//   store - a commit marks committed stores eligible, and a retire pops one eligible head.
// A squash trims younger entries from the tail and halts at any eligible entry.
// Assumes: the caller never pushes when full_o is 1, and squash has priority.
module lsq_ring
    import lsq_pkg::*;
#(
    parameter q_kind_e KIND  = Q_LOAD,
    parameter int      SLOTS = 5,
    parameter int      SEQ_W = 16,
    parameter int      IDX_W = 3,
    parameter int      CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [SEQ_W-1:0] push_seq_i,
    input  logic             cmp_valid_i,
    input  logic [SEQ_W-1:0] cmp_seq_i,
    input  logic             retire_i,
    input  logic             squash_i,
    input  logic [SEQ_W-1:0] squash_seq_i,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] tail_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             head_ready_o
);
    localparam int DEPTH = SLOTS - 1;

    logic [SEQ_W-1:0] seq_q [SLOTS];
    logic [SLOTS-1:0] elig_q;
    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SLOTS-1:0] occ;
    logic [CNT_W-1:0] pop_n;
    logic [CNT_W-1:0] keep_n;

    // wrap-around add of an offset below SLOTS to an index
    function automatic logic [IDX_W-1:0] idx_add(input logic [IDX_W-1:0] base, input int off);
        int s;
        s = int'(base) + off;
        if (s >= SLOTS) s = s - SLOTS;
        return IDX_W'(s);
    endfunction

    // mark which physical slots currently hold an entry
    always_comb begin
        occ = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (k < int'(cnt_q)) occ[idx_add(head_q, k)] = 1'b1;
        end
    end

    // count of entries kept by a squash: backward walk expressed from the head
    always_comb begin
        keep_n = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (k < int'(cnt_q)) begin
                if (!(seq_q[idx_add(head_q, k)] > squash_seq_i) || elig_q[idx_add(head_q, k)])
                    keep_n = CNT_W'(k + 1);
            end
        end
    end

    generate
        if (KIND == Q_LOAD) begin : g_load_pop
            // pop the leading committed loads in one cycle
            always_comb begin
                logic run;
                run   = cmp_valid_i;
                pop_n = '0;
                for (int k = 0; k < DEPTH; k++) begin
                    if (run && k < int'(cnt_q) && seq_q[idx_add(head_q, k)] <= cmp_seq_i)
                        pop_n = pop_n + 1'b1;
                    else
                        run = 1'b0;
                end
            end
        end else begin : g_store_pop
            // retire one head store, only when it is eligible
            always_comb begin
                pop_n = (retire_i && cnt_q != '0 && elig_q[head_q]) ? CNT_W'(1) : '0;
            end
        end
    endgenerate

    // pointer, count and eligibility update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            elig_q <= '0;
        end else if (squash_i) begin
            tail_q <= idx_add(head_q, int'(keep_n));
            cnt_q  <= keep_n;
        end else begin
            head_q <= idx_add(head_q, int'(pop_n));
            if (push_i) tail_q <= idx_add(tail_q, 1);
            cnt_q  <= cnt_q + CNT_W'(push_i) - pop_n;
            if (KIND == Q_STORE && cmp_valid_i) begin
                for (int j = 0; j < SLOTS; j++) begin
                    if (occ[j] && seq_q[j] <= cmp_seq_i) elig_q[j] <= 1'b1;
                end
            end
            if (push_i) elig_q[tail_q] <= 1'b0;
        end
    end

    // payload write at the tail
    always_ff @(posedge clk) begin
        if (push_i && !squash_i) seq_q[tail_q] <= push_seq_i;
    end

    assign head_o       = head_q;
    assign tail_o       = tail_q;
    assign count_o      = cnt_q;
    assign full_o       = (idx_add(tail_q, 1) == head_q);
    assign empty_o      = (head_q == tail_q);
    assign head_ready_o = (cnt_q != '0) && elig_q[head_q];

    // R2
    full_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o == (int'(cnt_q) == DEPTH));
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    // R12
    ptr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tail_q == idx_add(head_q, int'(cnt_q)));
    // R11
    squash_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_i |=> cnt_q <= $past(cnt_q));
    // R9
    squash_keeps_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_i && head_ready_o) |=> cnt_q != '0);
endmodule

// File: rtl/lsq_tracker.sv
// Top of the load/store queue tracker: two sentinel-slot rings plus shared free count.
// Gates allocations by type and fullness, and drops them in a squash cycle.
// Presents the slot and cross-queue link that a new entry receives.
// Assumes: allocations arrive in program order with rising sequence numbers.
module lsq_tracker
    import lsq_pkg::*;
#(
    parameter int LD_DEPTH = 4,
    parameter int ST_DEPTH = 3,
    parameter int SEQ_W    = 16,
    parameter int LD_SLOTS = LD_DEPTH + 1,
    parameter int ST_SLOTS = ST_DEPTH + 1,
    parameter int MAX_SLOTS = (LD_SLOTS > ST_SLOTS) ? LD_SLOTS : ST_SLOTS,
    parameter int IDX_W    = $clog2(MAX_SLOTS),
    parameter int CNT_W    = $clog2(MAX_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic             alloc_is_store,
    input  logic [SEQ_W-1:0] alloc_seq,
    output logic             alloc_taken,
    output logic [IDX_W-1:0] alloc_idx,
    output logic [IDX_W-1:0] alloc_link,
    output logic             alloc_link_none,
    input  logic             commit_valid,
    input  logic [SEQ_W-1:0] commit_seq,
    input  logic             st_retire,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    output logic [IDX_W-1:0] ld_head,
    output logic [IDX_W-1:0] ld_tail,
    output logic [CNT_W-1:0] ld_count,
    output logic             ld_full,
    output logic [IDX_W-1:0] st_head,
    output logic [IDX_W-1:0] st_tail,
    output logic [CNT_W-1:0] st_count,
    output logic             st_full,
    output logic             st_head_ready,
    output logic [CNT_W-1:0] free_slots
);
    logic ld_push, st_push;
    logic ld_empty, st_empty;
    logic ld_ready_unused;

    // accept an allocation when its queue has room and no squash is active
    always_comb begin
        ld_push     = alloc_valid && !alloc_is_store && !ld_full && !squash_valid;
        st_push     = alloc_valid &&  alloc_is_store && !st_full && !squash_valid;
        alloc_taken = ld_push || st_push;
    end

    // slot and cross-link seen by the entry being allocated
    always_comb begin
        alloc_idx       = alloc_is_store ? st_tail : ld_tail;
        alloc_link      = alloc_is_store ? ld_tail : st_tail;
        alloc_link_none = !alloc_is_store && st_empty;
    end

    lsq_ring #(
        .KIND(Q_LOAD), .SLOTS(LD_SLOTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) i_ld_ring (
        .clk(clk), .rst_n(rst_n),
        .push_i(ld_push), .push_seq_i(alloc_seq),
        .cmp_valid_i(commit_valid), .cmp_seq_i(commit_seq),
        .retire_i(1'b0),
        .squash_i(squash_valid), .squash_seq_i(squash_seq),
        .head_o(ld_head), .tail_o(ld_tail), .count_o(ld_count),
        .full_o(ld_full), .empty_o(ld_empty), .head_ready_o(ld_ready_unused)
    );

    lsq_ring #(
        .KIND(Q_STORE), .SLOTS(ST_SLOTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) i_st_ring (
        .clk(clk), .rst_n(rst_n),
        .push_i(st_push), .push_seq_i(alloc_seq),
        .cmp_valid_i(commit_valid), .cmp_seq_i(commit_seq),
        .retire_i(st_retire),
        .squash_i(squash_valid), .squash_seq_i(squash_seq),
        .head_o(st_head), .tail_o(st_tail), .count_o(st_count),
        .full_o(st_full), .empty_o(st_empty), .head_ready_o(st_head_ready)
    );

    lsq_free_calc #(
        .LD_DEPTH(LD_DEPTH), .ST_DEPTH(ST_DEPTH), .CNT_W(CNT_W)
    ) i_free (
        .ld_cnt_i(ld_count), .st_cnt_i(st_count), .free_o(free_slots)
    );

    // R5
    free_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_slots == '0) |-> (ld_full || st_full));
    // R11
    squash_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> !alloc_taken);
    // R3
    link_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_link_none |-> (st_count == '0));
endmodule

// File: tb/test_lsq_tracker.sv
module test_lsq_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0, alloc_is_store = 1'b0;
    logic [15:0] alloc_seq = '0;
    logic alloc_taken, alloc_link_none;
    logic [2:0] alloc_idx, alloc_link;
    logic commit_valid = 1'b0;
    logic [15:0] commit_seq = '0;
    logic st_retire = 1'b0;
    logic squash_valid = 1'b0;
    logic [15:0] squash_seq = '0;
    logic [2:0] ld_head, ld_tail, ld_count, st_head, st_tail, st_count, free_slots;
    logic ld_full, st_full, st_head_ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lsq_tracker i_lsq_tracker (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store), .alloc_seq(alloc_seq),
        .alloc_taken(alloc_taken), .alloc_idx(alloc_idx), .alloc_link(alloc_link),
        .alloc_link_none(alloc_link_none),
        .commit_valid(commit_valid), .commit_seq(commit_seq), .st_retire(st_retire),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .ld_head(ld_head), .ld_tail(ld_tail), .ld_count(ld_count), .ld_full(ld_full),
        .st_head(st_head), .st_tail(st_tail), .st_count(st_count), .st_full(st_full),
        .st_head_ready(st_head_ready), .free_slots(free_slots)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // one clock edge, then settle away from the edge and release strobes
    task automatic tick();
        @(posedge clk);
        #2;
        alloc_valid = 1'b0; commit_valid = 1'b0; st_retire = 1'b0; squash_valid = 1'b0;
        #1;
    endtask

    task automatic alloc(input bit is_st, input int seq);
        alloc_valid = 1'b1; alloc_is_store = is_st; alloc_seq = 16'(seq);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1", "ld_count", int'(ld_count), 0);
        chk("R1", "st_count", int'(st_count), 0);
        chk("R1", "heads/tails", int'({ld_head, ld_tail, st_head, st_tail}), 0);
        chk("R1", "free_slots", int'(free_slots), 3);
        chk("R1", "st_head_ready", int'(st_head_ready), 0);
    endtask

    task automatic t_links();
        alloc(1'b0, 10); #1;
        chk("R3", "idx of first load", int'(alloc_idx), 0);
        chk("R3", "link_none with empty store queue", int'(alloc_link_none), 1);
        tick();
        chk("R12", "ld_tail after load", int'(ld_tail), 1);
        chk("R12", "ld_count after load", int'(ld_count), 1);
        alloc(1'b1, 11); #1;
        chk("R4", "store link = load tail", int'(alloc_link), 1);
        chk("R4", "store idx", int'(alloc_idx), 0);
        chk("R4", "store link_none", int'(alloc_link_none), 0);
        tick();
        alloc(1'b0, 12); #1;
        chk("R3", "load link = store tail", int'(alloc_link), 1);
        chk("R3", "load link_none", int'(alloc_link_none), 0);
        chk("R3", "load idx", int'(alloc_idx), 1);
        tick();
        chk("R5", "free after 2 loads 1 store", int'(free_slots), 2);
    endtask

    task automatic t_commit();
        commit_valid = 1'b1; commit_seq = 16'd11;
        tick();
        chk("R6", "ld_head after partial commit", int'(ld_head), 1);
        chk("R6", "ld_count after partial commit", int'(ld_count), 1);
        chk("R7", "store marked eligible", int'(st_head_ready), 1);
        commit_valid = 1'b1; commit_seq = 16'd12;
        tick();
        chk("R6", "ld_count after full commit", int'(ld_count), 0);
        chk("R6", "ld_head after full commit", int'(ld_head), 2);
        st_retire = 1'b1;
        tick();
        chk("R7", "st_head after retire", int'(st_head), 1);
        chk("R7", "st_count after retire", int'(st_count), 0);
    endtask

    task automatic t_full_wrap();
        for (int i = 0; i < 3; i++) begin
            alloc(1'b1, 20 + i);
            tick();
        end
        chk("R10", "st_tail wrapped", int'(st_tail), 0);
        chk("R2", "st_full", int'(st_full), 1);
        chk("R5", "free with full store queue", int'(free_slots), 0);
        alloc(1'b1, 23); #1;
        chk("R2", "alloc to full dropped", int'(alloc_taken), 0);
        tick();
        chk("R2", "st_count unchanged", int'(st_count), 3);
        for (int i = 0; i < 4; i++) begin
            alloc(1'b0, 30 + i);
            tick();
        end
        chk("R10", "ld_tail wrapped", int'(ld_tail), 1);
        chk("R2", "ld_full", int'(ld_full), 1);
    endtask

    task automatic t_squash();
        commit_valid = 1'b1; commit_seq = 16'd20;
        tick();
        squash_valid = 1'b1; squash_seq = 16'd19;
        alloc(1'b1, 40); #1;
        chk("R11", "alloc in squash cycle", int'(alloc_taken), 0);
        tick();
        chk("R8", "all loads squashed", int'(ld_count), 0);
        chk("R8", "ld_tail back to head", int'(ld_tail), 2);
        chk("R9", "store walk stopped at eligible", int'(st_count), 1);
        chk("R9", "st_tail after squash", int'(st_tail), 2);
        for (int i = 0; i < 3; i++) begin
            alloc(1'b0, 40 + i);
            tick();
        end
        squash_valid = 1'b1; squash_seq = 16'd40;
        tick();
        chk("R8", "partial load squash count", int'(ld_count), 1);
        chk("R8", "partial load squash tail", int'(ld_tail), 3);
        commit_valid = 1'b1; commit_seq = 16'd39;
        tick();
        chk("R6", "younger head not popped", int'(ld_count), 1);
    endtask

    task automatic t_retire_rules();
        alloc(1'b1, 45);
        tick();
        st_retire = 1'b1;
        tick();
        chk("R7", "eligible head retired", int'(st_head), 2);
        st_retire = 1'b1;
        tick();
        chk("R7", "non-eligible retire ignored", int'(st_count), 1);
        chk("R7", "head not ready", int'(st_head_ready), 0);
        commit_valid = 1'b1; commit_seq = 16'd45;
        tick();
        chk("R7", "store 45 eligible", int'(st_head_ready), 1);
        squash_valid = 1'b1; squash_seq = 16'd100; st_retire = 1'b1;
        tick();
        chk("R11", "retire ignored during squash", int'(st_count), 1);
    endtask

    initial begin
        t_reset();
        t_links();
        t_commit();
        t_full_wrap();
        t_squash();
        t_retire_rules();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule